// File: doc/BRIEF.md
# Acquisition Control/Status Register Bank

This block is the 16-bit register bank of a multi-channel transient recorder. It sits behind a simple synchronous bus port that carries an address, a write strobe, write data, byte lane enables and combinational read data. Software uses the bank to pick the sample clock source, the trigger behaviour and the acquisition mode, and to start or stop a capture. It also uses the bank to place the sample memory in the bus address space and to read back the live conversion address, the trigger address and the start address.

The acquisition engine reports two events into the bank: a stop event and a memory-full event. The bank keeps the Busy state. It enforces the interlock between Busy and the memory-access enable bit. While that bit is set, no capture can start and the memory belongs to the bus. While a capture is running, the bit cannot be set.

Top module: `acq_csr_bank`

## Requirements
- R1: The bank is selected only when `bus_addr[15:14]` is 2'b11, `bus_addr[13:6]` equals `mod_addr` and `bus_addr[0]` is 0. `bus_addr[5:1]` is the register index (byte offset / 2). When the bank is not selected, or the index names no register, the read data is 0 and writes have no effect.
- R2: Offset 0x00 reads the identity word 0x1F7F. Offset 0x02 reads 0x30F8 when `quad_strap` is 1 and 0x5808 when it is 0. A write to offset 0x02 has no effect.
- R3: At offset 0x04, a write with `bus_be[0]`=1 and data bit 0 = 1 clears every control bit and Busy. Read bit 0 returns Busy. Read bits 15:1 return the last value written, changed only as R4 and R6 describe.
- R4: Bit 15 of offset 0x04 is the memory-access enable, and `acq_inhibit` follows it. A write of 1 to it is ignored while Busy is 1. While it is 1, a start or continue command does not set Busy.
- R5: A write to offset 0x04 sets Busy when it has `bus_be[0]`=1, data bit 0 = 0, data bit 2 (start) or data bit 4 (continue) set, and bit 15 is 0 after the write.
- R6: A `hw_stop` pulse sets bit 3 (stop) and clears Busy. A `hw_full` pulse sets bit 6 (full). When bit 5 (ring) is 0, the `hw_full` pulse also sets bit 3 and clears Busy. `irq` is bit 7 AND bit 3.
- R7: The interrupt vector is written at offset 0x00 and read back at offset 0x0C. `irq_vector` shows it.
- R8: At offset 0x06 only bits 15:7 are stored. Bits 6:0 read as 0. `mem_base` carries the stored bits, which are memory address bits 31:23.
- R9: Each 20-bit value is split into a low word and a high word, and the high word uses only bits 3:0; its bits 15:4 read 0. The conversion address is at 0x08/0x0A and the preset count at 0x12/0x14; the preset count is writable and drives `preset_count`. The 32-bit trigger address is read at 0x0E/0x10 and the 32-bit start address at 0x16/0x18.
- R10: `rst_n` low clears the control bits, Busy, the memory offset and the vector. The preset count keeps its value.
- R11: `bus_be[1]` enables write data bits 15:8 and `bus_be[0]` enables bits 7:0. Either lane can be written alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| mod_addr | input | 8 | Strapped module address |
| quad_strap | input | 1 | Channel-count strap, 1 = four channels |
| bus_addr | input | 16 | Bus byte address |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 2 | Byte lane enables |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| hw_stop | input | 1 | Stop event from the acquisition engine |
| hw_full | input | 1 | Memory-full event from the acquisition engine |
| conv_addr | input | 20 | Current conversion address |
| trig_addr | input | 32 | Latched trigger address |
| start_addr | input | 32 | Latched triggered-start address |
| acq_inhibit | output | 1 | Memory-access enable, which inhibits acquisition |
| acq_busy | output | 1 | Busy state |
| irq | output | 1 | Interrupt request |
| smp_clk_sel | output | 3 | Sample clock selection |
| arm_hw | output | 1 | Hardware start/stop arm |
| lat_sel | output | 3 | Latency compensation interval select |
| pretrig_en | output | 1 | Pre-trigger mode enable |
| ring_en | output | 1 | Ring buffer mode enable |
| mem_base | output | 9 | Memory base address bits 31:23 |
| irq_vector | output | 16 | Interrupt vector |
| preset_count | output | 20 | Preset sample count |

## Verification
If the stored Busy or enable state is wrong, it shows in the very next read of offset 0x04 through bit 0 or bit 15. It also shows at once on `acq_busy` and `acq_inhibit`, one clock after the write or event that caused it. Decode faults show up at once as wrong or nonzero combinational read data, for example a register answering at the wrong offset or an unselected address returning a value. A lost byte-lane merge or a wrongly retained reset value stays hidden until that register is read back. The bench therefore reads every register right after each write, event and reset.

// File: rtl/csrb_pkg.sv
package csrb_pkg;
  localparam int DW    = 16;
  localparam int IDX_W = 5;
  localparam int MOD_W = 8;

  // Register index = byte offset / 2
  typedef enum logic [IDX_W-1:0] {
    IX_ID     = 5'd0,
    IX_DTYPE  = 5'd1,
    IX_CSR    = 5'd2,
    IX_MOFF   = 5'd3,
    IX_CNV_LO = 5'd4,
    IX_CNV_HI = 5'd5,
    IX_VEC    = 5'd6,
    IX_TRG_LO = 5'd7,
    IX_TRG_HI = 5'd8,
    IX_PRE_LO = 5'd9,
    IX_PRE_HI = 5'd10,
    IX_STA_LO = 5'd11,
    IX_STA_HI = 5'd12
  } reg_ix_e;

  // Control word bit positions
  localparam int B_MEMEN = 15;
  localparam int B_IRQEN = 7;
  localparam int B_FULL  = 6;
  localparam int B_RING  = 5;
  localparam int B_CONT  = 4;
  localparam int B_STOP  = 3;
  localparam int B_START = 2;
  localparam int B_PRE   = 1;
  localparam int B_RST   = 0;

  function automatic logic win_hit(input logic [DW-1:0] a, input logic [MOD_W-1:0] m);
    return (a[15:14] == 2'b11) && (a[13:6] == m) && !a[0];
  endfunction

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
                                               input logic [DW-1:0] new_w,
                                               input logic [1:0]    be);
    return {be[1] ? new_w[15:8] : old_w[15:8], be[0] ? new_w[7:0] : old_w[7:0]};
  endfunction

  function automatic logic [DW-1:0] word_of(input logic [31:0] v, input logic hi);
    return hi ? v[31:16] : v[15:0];
  endfunction
endpackage

// File: rtl/csrb_decode.sv
module csrb_decode
  import csrb_pkg::*;
(
  input  logic [DW-1:0]    addr,
  input  logic [MOD_W-1:0] mod_addr,
  input  logic             wr,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output logic             wr_hit
);
  assign hit    = win_hit(addr, mod_addr);
  assign idx    = addr[IDX_W:1];
  assign wr_hit = wr & hit;
endmodule

// File: rtl/csrb_ctrl.sv
module csrb_ctrl
  import csrb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_csr,
  input  logic [1:0]    be,
  input  logic [DW-1:0] wdata,
  input  logic          hw_stop,
  input  logic          hw_full,
  output logic [DW-1:0] csr_word,
  output logic          busy,
  output logic          memen
);
  logic [DW-1:1] ctrl_q, ctrl_d;
  logic          busy_q, busy_d;
  logic [DW-1:0] wr_word;
  logic          rst_cmd, start_cmd, stop_hit, new_memen;

  always_comb begin
    rst_cmd   = we_csr & be[0] & wdata[B_RST];
    wr_word   = we_csr ? lane_merge({ctrl_q, 1'b0}, wdata, be) : {ctrl_q, 1'b0};
    new_memen = wr_word[B_MEMEN] & ~busy_q;
    stop_hit  = hw_stop | (hw_full & ~wr_word[B_RING]);
    start_cmd = we_csr & be[0] & ~wdata[B_RST] &
                (wdata[B_START] | wdata[B_CONT]) & ~new_memen;

    ctrl_d          = wr_word[DW-1:1];
    ctrl_d[B_MEMEN] = new_memen;
    ctrl_d[B_STOP]  = wr_word[B_STOP] | stop_hit;
    ctrl_d[B_FULL]  = wr_word[B_FULL] | hw_full;
    if (rst_cmd) ctrl_d = '0;

    if (rst_cmd)        busy_d = 1'b0;
    else if (stop_hit)  busy_d = 1'b0;
    else if (start_cmd) busy_d = 1'b1;
    else                busy_d = busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      busy_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      busy_q <= busy_d;
    end
  end

  assign csr_word = {ctrl_q, busy_q};
  assign busy     = busy_q;
  assign memen    = ctrl_q[B_MEMEN];

  AST_BUSY_EXCLUDES_MEMEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !ctrl_q[B_MEMEN]); // R4
  AST_RST_BIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd |=> (ctrl_q == '0) && !busy_q); // R3
  AST_STOP_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stop |=> !busy_q && ctrl_q[B_STOP]); // R6
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && !stop_hit && !rst_cmd) |=> busy_q); // R5
endmodule

// File: rtl/csrb_store.sv
module csrb_store
  import csrb_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int KEEP_LSB = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       be,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    vector,
  output logic [DW-1:KEEP_LSB] moff,
  output logic [CNT_W-1:0] preset
);
  localparam int HI_W = CNT_W - DW;

  logic vec_we, moff_we, plo_we, phi_we;
  logic [DW-1:0] moff_full, phi_full;

  assign vec_we  = wr_hit && (idx == IX_ID);
  assign moff_we = wr_hit && (idx == IX_MOFF);
  assign plo_we  = wr_hit && (idx == IX_PRE_LO);
  assign phi_we  = wr_hit && (idx == IX_PRE_HI);

  assign moff_full = lane_merge({moff, {KEEP_LSB{1'b0}}}, wdata, be);
  assign phi_full  = lane_merge({{(DW-HI_W){1'b0}}, preset[CNT_W-1:DW]}, wdata, be);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vector <= '0;
      moff   <= '0;
    end else begin
      if (vec_we)  vector <= lane_merge(vector, wdata, be);
      if (moff_we) moff   <= moff_full[DW-1:KEEP_LSB];
    end
  end

  // Preset count deliberately outside the system reset
  always_ff @(posedge clk) begin
    if (plo_we) preset[DW-1:0]    <= lane_merge(preset[DW-1:0], wdata, be);
    if (phi_we) preset[CNT_W-1:DW] <= phi_full[HI_W-1:0];
  end

  AST_VECTOR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_we |=> $stable(vector)); // R7
  AST_OFFSET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !moff_we |=> $stable(moff)); // R8
endmodule

// File: rtl/csrb_rdmux.sv
module csrb_rdmux
  import csrb_pkg::*;
#(
  parameter int          CNT_W    = 20,
  parameter int          KEEP_LSB = 7,
  parameter logic [15:0] ID_WORD  = 16'h1F7F,
  parameter logic [15:0] DT_QUAD  = 16'h30F8,
  parameter logic [15:0] DT_OCT   = 16'h5808
) (
  input  logic             hit,
  input  logic [IDX_W-1:0] idx,
  input  logic             quad,
  input  logic [DW-1:0]    csr_word,
  input  logic [DW-1:0]    vector,
  input  logic [DW-1:KEEP_LSB] moff,
  input  logic [CNT_W-1:0] preset,
  input  logic [CNT_W-1:0] conv,
  input  logic [31:0]      trig,
  input  logic [31:0]      start,
  output logic [DW-1:0]    rdata
);
  logic [31:0] conv32, pre32;
  assign conv32 = {{(32-CNT_W){1'b0}}, conv};
  assign pre32  = {{(32-CNT_W){1'b0}}, preset};

  always_comb begin
    rdata = '0;
    if (hit) begin
      case (idx)
        IX_ID:     rdata = ID_WORD;
        IX_DTYPE:  rdata = quad ? DT_QUAD : DT_OCT;
        IX_CSR:    rdata = csr_word;
        IX_MOFF:   rdata = {moff, {KEEP_LSB{1'b0}}};
        IX_CNV_LO: rdata = word_of(conv32, 1'b0);
        IX_CNV_HI: rdata = word_of(conv32, 1'b1);
        IX_VEC:    rdata = vector;
        IX_TRG_LO: rdata = word_of(trig, 1'b0);
        IX_TRG_HI: rdata = word_of(trig, 1'b1);
        IX_PRE_LO: rdata = word_of(pre32, 1'b0);
        IX_PRE_HI: rdata = word_of(pre32, 1'b1);
        IX_STA_LO: rdata = word_of(start, 1'b0);
        IX_STA_HI: rdata = word_of(start, 1'b1);
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/acq_csr_bank.sv
module acq_csr_bank
  import csrb_pkg::*;
#(
  parameter int          CNT_W   = 20,
  parameter logic [15:0] ID_WORD = 16'h1F7F,
  parameter logic [15:0] DT_QUAD = 16'h30F8,
  parameter logic [15:0] DT_OCT  = 16'h5808
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       mod_addr,
  input  logic             quad_strap,
  input  logic [15:0]      bus_addr,
  input  logic             bus_wr,
  input  logic [1:0]       bus_be,
  input  logic [15:0]      bus_wdata,
  output logic [15:0]      bus_rdata,
  input  logic             hw_stop,
  input  logic             hw_full,
  input  logic [CNT_W-1:0] conv_addr,
  input  logic [31:0]      trig_addr,
  input  logic [31:0]      start_addr,
  output logic             acq_inhibit,
  output logic             acq_busy,
  output logic             irq,
  output logic [2:0]       smp_clk_sel,
  output logic             arm_hw,
  output logic [2:0]       lat_sel,
  output logic             pretrig_en,
  output logic             ring_en,
  output logic [8:0]       mem_base,
  output logic [15:0]      irq_vector,
  output logic [CNT_W-1:0] preset_count
);
  localparam int KEEP_LSB = 7;
  localparam int HI_W     = CNT_W - DW;

  logic             hit, wr_hit, we_csr;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    csr_word, vector;
  logic [DW-1:KEEP_LSB] moff;
  logic [CNT_W-1:0] preset;
  logic             busy, memen;

  csrb_decode u_dec (
    .addr(bus_addr), .mod_addr(mod_addr), .wr(bus_wr),
    .hit(hit), .idx(idx), .wr_hit(wr_hit)
  );

  assign we_csr = wr_hit && (idx == IX_CSR);

  csrb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .we_csr(we_csr), .be(bus_be), .wdata(bus_wdata),
    .hw_stop(hw_stop), .hw_full(hw_full),
    .csr_word(csr_word), .busy(busy), .memen(memen)
  );

  csrb_store #(.CNT_W(CNT_W), .KEEP_LSB(KEEP_LSB)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .idx(idx), .be(bus_be),
    .wdata(bus_wdata), .vector(vector), .moff(moff), .preset(preset)
  );

  csrb_rdmux #(.CNT_W(CNT_W), .KEEP_LSB(KEEP_LSB), .ID_WORD(ID_WORD),
               .DT_QUAD(DT_QUAD), .DT_OCT(DT_OCT)) u_rd (
    .hit(hit), .idx(idx), .quad(quad_strap), .csr_word(csr_word),
    .vector(vector), .moff(moff), .preset(preset), .conv(conv_addr),
    .trig(trig_addr), .start(start_addr), .rdata(bus_rdata)
  );

  assign acq_inhibit  = memen;
  assign acq_busy     = busy;
  assign irq          = csr_word[B_IRQEN] & csr_word[B_STOP];
  assign smp_clk_sel  = csr_word[14:12];
  assign arm_hw       = csr_word[11];
  assign lat_sel      = csr_word[10:8];
  assign pretrig_en   = csr_word[B_PRE];
  assign ring_en      = csr_word[B_RING];
  assign mem_base     = moff;
  assign irq_vector   = vector;
  assign preset_count = preset;

  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (bus_rdata == '0)); // R1
  AST_HI_WORD_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && (idx == IX_PRE_HI || idx == IX_CNV_HI)) |-> (bus_rdata[DW-1:HI_W] == '0)); // R9
  AST_DTYPE_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && idx == IX_DTYPE) |=> $stable(csr_word) && $stable(vector)); // R2
endmodule

// File: tb/acq_csr_bank_bench.sv
`timescale 1ns/1ps
module acq_csr_bank_bench;
  localparam logic [7:0] MOD = 8'hA5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mod_addr = MOD;
  logic        quad_strap = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_be = 2'b11;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        hw_stop = 1'b0, hw_full = 1'b0;
  logic [19:0] conv_addr = '0;
  logic [31:0] trig_addr = '0, start_addr = '0;
  logic        acq_inhibit, acq_busy, irq, arm_hw, pretrig_en, ring_en;
  logic [2:0]  smp_clk_sel, lat_sel;
  logic [8:0]  mem_base;
  logic [15:0] irq_vector;
  logic [19:0] preset_count;

  int vecs = 0, miss = 0;
  bit done = 0;

  always #10 clk = ~clk;

  acq_csr_bank u_acq_csr_bank (
    .clk(clk), .rst_n(rst_n), .mod_addr(mod_addr), .quad_strap(quad_strap),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .hw_stop(hw_stop), .hw_full(hw_full),
    .conv_addr(conv_addr), .trig_addr(trig_addr), .start_addr(start_addr),
    .acq_inhibit(acq_inhibit), .acq_busy(acq_busy), .irq(irq),
    .smp_clk_sel(smp_clk_sel), .arm_hw(arm_hw), .lat_sel(lat_sel),
    .pretrig_en(pretrig_en), .ring_en(ring_en), .mem_base(mem_base),
    .irq_vector(irq_vector), .preset_count(preset_count)
  );

  function automatic logic [15:0] ra(input logic [4:0] ix);
    return {2'b11, MOD, ix, 1'b0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      miss++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr16(input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [15:0] exp);
    bus_addr = a;
    #1;
    chk(tag, {16'h0, bus_rdata}, {16'h0, exp});
  endtask

  task automatic pulse(input bit stop_not_full);
    @(negedge clk);
    if (stop_not_full) hw_stop = 1'b1; else hw_full = 1'b1;
    @(negedge clk);
    hw_stop = 1'b0; hw_full = 1'b0;
  endtask

  task automatic t_reset_state;
    rd_chk("R10 csr after reset", ra(5'd2), 16'h0000);
    rd_chk("R10 offset after reset", ra(5'd3), 16'h0000);
    rd_chk("R10 vector after reset", ra(5'd6), 16'h0000);
    rd_chk("R2 identity", ra(5'd0), 16'h1F7F);
    quad_strap = 1'b0;
    rd_chk("R2 devtype octal", ra(5'd1), 16'h5808);
    quad_strap = 1'b1;
    rd_chk("R2 devtype quad", ra(5'd1), 16'h30F8);
    wr16(ra(5'd1), 16'hFFFF, 2'b11);
    rd_chk("R2 devtype write ignored", ra(5'd1), 16'h30F8);
    chk("R2 devtype write no csr effect", {31'b0, acq_busy}, 32'd0);
  endtask

  task automatic t_window;
    rd_chk("R1 wrong module addr", {2'b11, 8'h5A, 5'd0, 1'b0}, 16'h0000);
    rd_chk("R1 odd address", ra(5'd0) | 16'h0001, 16'h0000);
    rd_chk("R1 top bits not 11", ra(5'd0) & 16'h7FFF, 16'h0000);
    rd_chk("R1 unused index", ra(5'd13), 16'h0000);
    wr16({2'b11, 8'h5A, 5'd0, 1'b0}, 16'h4321, 2'b11);
    rd_chk("R1 foreign write ignored", ra(5'd6), 16'h0000);
  endtask

  task automatic t_vector;
    wr16(ra(5'd0), 16'h1234, 2'b11);
    rd_chk("R7 vector readback", ra(5'd6), 16'h1234);
    rd_chk("R7 offset 0 still identity", ra(5'd0), 16'h1F7F);
    chk("R7 irq_vector port", {16'h0, irq_vector}, 32'h1234);
    wr16(ra(5'd0), 16'hFFFF, 2'b01);
    rd_chk("R11 low lane only", ra(5'd6), 16'h12FF);
    wr16(ra(5'd0), 16'hAB00, 2'b10);
    rd_chk("R11 high lane only", ra(5'd6), 16'hABFF);
  endtask

  task automatic t_offset;
    wr16(ra(5'd3), 16'hFFFF, 2'b11);
    rd_chk("R8 low bits read zero", ra(5'd3), 16'hFF80);
    chk("R8 mem_base", {23'h0, mem_base}, 32'h1FF);
    wr16(ra(5'd3), 16'h0000, 2'b01);
    rd_chk("R8 R11 low lane clears bit 7", ra(5'd3), 16'hFF00);
  endtask

  task automatic t_split;
    wr16(ra(5'd9), 16'hBEEF, 2'b11);
    wr16(ra(5'd10), 16'hFFFF, 2'b11);
    rd_chk("R9 preset low", ra(5'd9), 16'hBEEF);
    rd_chk("R9 preset high narrow", ra(5'd10), 16'h000F);
    chk("R9 preset port", {12'h0, preset_count}, 32'hFBEEF);
    conv_addr = 20'hABCDE; trig_addr = 32'h89ABCDEF; start_addr = 32'h01234567;
    rd_chk("R9 conv low", ra(5'd4), 16'hBCDE);
    rd_chk("R9 conv high", ra(5'd5), 16'h000A);
    rd_chk("R9 trig low", ra(5'd7), 16'hCDEF);
    rd_chk("R9 trig high", ra(5'd8), 16'h89AB);
    rd_chk("R9 start low", ra(5'd11), 16'h4567);
    rd_chk("R9 start high", ra(5'd12), 16'h0123);
  endtask

  task automatic t_csr_rw;
    wr16(ra(5'd2), 16'h7BA2, 2'b11);
    rd_chk("R3 csr readback", ra(5'd2), 16'h7BA2);
    chk("R3 field ports", {24'h0, smp_clk_sel, arm_hw, lat_sel, pretrig_en},
        {24'h0, 3'b111, 1'b1, 3'b011, 1'b1});
    wr16(ra(5'd2), 16'h0001, 2'b10);
    rd_chk("R11 reset bit needs low lane", ra(5'd2), 16'h00A2);
    wr16(ra(5'd2), 16'h0001, 2'b11);
    rd_chk("R3 reset bit clears", ra(5'd2), 16'h0000);
  endtask

  task automatic t_busy;
    wr16(ra(5'd2), 16'h0004, 2'b11);
    rd_chk("R5 start sets busy", ra(5'd2), 16'h0005);
    chk("R5 busy port", {31'b0, acq_busy}, 32'd1);
    wr16(ra(5'd2), 16'h8004, 2'b11);
    rd_chk("R4 memen write ignored while busy", ra(5'd2), 16'h0005);
    chk("R4 inhibit stays low", {31'b0, acq_inhibit}, 32'd0);
    pulse(1'b1);
    rd_chk("R6 hw stop", ra(5'd2), 16'h000C);
    chk("R6 irq masked", {31'b0, irq}, 32'd0);
    wr16(ra(5'd2), 16'h0088, 2'b11);
    chk("R6 irq on stop", {31'b0, irq}, 32'd1);
    wr16(ra(5'd2), 16'h0014, 2'b11);
    rd_chk("R5 continue sets busy", ra(5'd2), 16'h0015);
  endtask

  task automatic t_full;
    wr16(ra(5'd2), 16'h0024, 2'b11);
    pulse(1'b0);
    rd_chk("R6 full in ring mode keeps busy", ra(5'd2), 16'h0065);
    chk("R6 ring port", {31'b0, ring_en}, 32'd1);
    wr16(ra(5'd2), 16'h0004, 2'b11);
    pulse(1'b0);
    rd_chk("R6 full stops without ring", ra(5'd2), 16'h004C);
  endtask

  task automatic t_memen;
    wr16(ra(5'd2), 16'h8000, 2'b11);
    rd_chk("R4 memen set when idle", ra(5'd2), 16'h8000);
    chk("R4 inhibit port", {31'b0, acq_inhibit}, 32'd1);
    wr16(ra(5'd2), 16'h8004, 2'b11);
    rd_chk("R4 start blocked by memen", ra(5'd2), 16'h8004);
    wr16(ra(5'd2), 16'h0004, 2'b11);
    rd_chk("R4 R5 start after memen cleared", ra(5'd2), 16'h0005);
  endtask

  task automatic t_sysreset;
    wr16(ra(5'd0), 16'h5555, 2'b11);
    wr16(ra(5'd3), 16'h1280, 2'b11);
    wr16(ra(5'd9), 16'h0F0F, 2'b11);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    rd_chk("R10 csr cleared", ra(5'd2), 16'h0000);
    rd_chk("R10 vector cleared", ra(5'd6), 16'h0000);
    rd_chk("R10 offset cleared", ra(5'd3), 16'h0000);
    rd_chk("R10 preset kept", ra(5'd9), 16'h0F0F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_window();
    t_vector();
    t_offset();
    t_split();
    t_csr_rw();
    t_busy();
    t_full();
    t_memen();
    t_sysreset();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      vecs++; miss++;
      $display("FAIL watchdog expired, all R checks incomplete got 1 exp 0");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end
endmodule